// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single 16-bit down-counting timer channel driven by a count-enable pulse in the system clock domain. A host programs it over an 8-bit bus. A control byte chooses one of six waveform modes, how many count bytes are written, and whether the count runs in binary or in four BCD digits. A count write then starts the timer or arms it. A gate input can suspend counting in some modes and trigger it in others. The channel drives one output line, `wave_out`. The six modes are: an interrupt at terminal count, a retriggerable one-shot, a divide-by-N rate generator, a square wave, a strobe started by software, and a strobe started by a gate edge.

The bus is a plain register port, not a stream. Each system clock cycle in which chip select and write (or read) are both low counts as exactly one access. A host that holds the strobes low for several cycles performs that many accesses. The live count can be read back one byte at a time.

Top module: `pit_channel`

## Requirements
- R1: A write is an access where `cs_n`=0 and `wr_n`=0. Address 2'b11 writes the control byte, and the address equal to parameter `CHAN_ID` writes count bytes. The control byte fields are: bits 7:6 channel select, bits 5:4 byte format, bits 3:1 mode, bit 0 BCD when 1. The channel ignores a control byte whose select differs from `CHAN_ID`, a control byte with format 2'b00, and any access while `cs_n`=1. Mode codes 6 and 7 act as modes 2 and 3.
- R2: Format 01 loads the low byte with the high byte cleared. Format 10 loads the high byte with the low byte cleared. Format 11 takes the low byte and then the high byte, and the count takes effect only on the second write.
- R3: While `cs_n`=0, `rd_n`=0 and `addr`=`CHAN_ID`, `dout` shows a byte of the live count. Format 01 gives the low byte and format 10 the high byte. Format 11 gives the low byte on the first read and the high byte on the next, alternating.
- R4: Reset selects mode 0, format 11 and binary counting, holds `wave_out` high, loads no count and reads back 0.
- R5: Mode 0: a count write drives `wave_out` low. The output goes high on the Nth count tick and stays high until the next count write.
- R6: Mode 1: after a count write, each rising gate edge loads N and drives `wave_out` low. The output returns high on the Nth tick after the latest edge, so a new edge retriggers the pulse. Gate edges before the first count write are ignored.
- R7: Mode 2: `wave_out` is high for N-1 ticks and low for 1 tick, repeating with period N.
- R8: Mode 3: `wave_out` is high for ceil(N/2) ticks and low for floor(N/2) ticks, repeating.
- R9: Mode 4: counting starts at the count write. On the Nth tick `wave_out` goes low for exactly one tick, then stays high.
- R10: Mode 5: counting starts only after a rising gate edge. On the Nth tick after that edge, `wave_out` goes low for one tick.
- R11: In BCD the count steps down through four decimal digits and 0000 wraps to 9999, so a written 0 is 10000 ticks. In binary, a written 0 is 65536 ticks.
- R12: In modes 0, 2, 3 and 4, gate low freezes the count. In modes 2 and 3, gate low also forces `wave_out` high one cycle later.
- R13: A control write stops counting until a new count is written. It sets `wave_out` low for mode 0 and high for every other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low, one access per cycle |
| wr_n | input | 1 | Write strobe, active low, one access per cycle |
| addr | input | 2 | Register address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, a byte of the live count |
| cnt_en | input | 1 | Count tick, one system cycle wide |
| gate | input | 1 | Gate level and trigger |
| wave_out | output | 1 | Channel output waveform |

## Verification
Every write and every count tick changes `wave_out` and the count on the same clock edge that samples it. Gate edges are detected against the level stored on the previous edge, so a trigger applied at a falling edge acts on the next rising edge. The bench drives every stimulus at a falling edge, lets exactly one rising edge pass for each access or tick, and samples at the following falling edge. Read data is combinational from the count register, so the bench samples it partway through the read cycle, before the edge that advances the byte pointer.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int CNT_W  = 16;
  localparam int DIGITS = CNT_W / 4;

  typedef enum logic [2:0] {
    MD_TC_IRQ    = 3'd0,
    MD_ONESHOT   = 3'd1,
    MD_RATE      = 3'd2,
    MD_SQUARE    = 3'd3,
    MD_SW_STROBE = 3'd4,
    MD_HW_STROBE = 3'd5
  } mode_e;

  typedef enum logic [1:0] {
    FMT_NONE = 2'd0,
    FMT_LO   = 2'd1,
    FMT_HI   = 2'd2,
    FMT_BOTH = 2'd3
  } fmt_e;

  typedef struct packed {
    mode_e mode;
    fmt_e  fmt;
    logic  bcd;
  } cfg_t;

  function automatic logic [CNT_W-1:0] count_dec(input logic [CNT_W-1:0] v, input logic bcd);
    logic [CNT_W-1:0] r;
    logic borrow;
    if (!bcd) return v - {{(CNT_W-1){1'b0}}, 1'b1};
    r = v;
    borrow = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      if (borrow) begin
        if (v[4*i +: 4] == 4'd0) r[4*i +: 4] = 4'd9;
        else begin
          r[4*i +: 4] = v[4*i +: 4] - 4'd1;
          borrow = 1'b0;
        end
      end
    end
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] count_half(input logic [CNT_W-1:0] v, input logic bcd);
    logic [CNT_W-1:0] r;
    logic [3:0] d;
    logic carry;
    if (!bcd) begin
      if (v == '0) return {1'b1, {(CNT_W-1){1'b0}}};
      return v >> 1;
    end
    if (v == '0) return {4'd5, {(CNT_W-4){1'b0}}};
    r = '0;
    carry = 1'b0;
    for (int i = DIGITS-1; i >= 0; i--) begin
      d = v[4*i +: 4];
      r[4*i +: 4] = {1'b0, d[3:1]} + (carry ? 4'd5 : 4'd0);
      carry = d[0];
    end
    return r;
  endfunction
endpackage

// File: rtl/pit_bus.sv
module pit_bus
  import pit_pkg::*;
#(
  parameter int CHAN_ID = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic [1:0]       addr,
  input  logic [7:0]       din,
  input  logic [CNT_W-1:0] cnt,
  output cfg_t             cfg,
  output logic             cw_wr,
  output mode_e            cw_mode,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic [7:0]       dout
);
  localparam logic [1:0] SEL    = CHAN_ID[1:0];
  localparam logic [1:0] CW_ADR = 2'b11;

  logic       acc_wr, acc_rd, data_wr;
  logic       wr_hi, rd_hi;
  logic [7:0] lo_hold;

  assign acc_wr  = !cs_n && !wr_n;
  assign acc_rd  = !cs_n && !rd_n && wr_n && (addr == SEL);
  assign data_wr = acc_wr && (addr == SEL);
  assign cw_wr   = acc_wr && (addr == CW_ADR) && (din[7:6] == SEL) && (din[5:4] != FMT_NONE);
  assign cw_mode = din[2] ? mode_e'({1'b0, din[2:1]}) : mode_e'(din[3:1]);
  assign load    = data_wr && (cfg.fmt != FMT_BOTH || wr_hi);

  always_comb begin
    case (cfg.fmt)
      FMT_LO:  load_val = {8'h00, din};
      FMT_HI:  load_val = {din, 8'h00};
      default: load_val = {din, lo_hold};
    endcase
  end

  assign dout = (cfg.fmt == FMT_HI || (cfg.fmt == FMT_BOTH && rd_hi)) ? cnt[15:8] : cnt[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg     <= '{mode: MD_TC_IRQ, fmt: FMT_BOTH, bcd: 1'b0};
      wr_hi   <= 1'b0;
      rd_hi   <= 1'b0;
      lo_hold <= '0;
    end else if (cw_wr) begin
      cfg.mode <= cw_mode;
      cfg.fmt  <= fmt_e'(din[5:4]);
      cfg.bcd  <= din[0];
      wr_hi    <= 1'b0;
      rd_hi    <= 1'b0;
    end else begin
      if (data_wr && cfg.fmt == FMT_BOTH) begin
        if (!wr_hi) lo_hold <= din;
        wr_hi <= !wr_hi;
      end
      if (acc_rd && cfg.fmt == FMT_BOTH) rd_hi <= !rd_hi;
    end
  end

  // R1: a control byte for another channel leaves the configuration untouched
  assert_foreign_select_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && addr == CW_ADR && din[7:6] != SEL) |=> $stable(cfg))
    else $error("foreign select changed configuration");

  // R2: the first byte of a two-byte count arms the high-byte step
  assert_two_byte_pointer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && cfg.fmt == FMT_BOTH && !wr_hi) |=> wr_hi)
    else $error("two-byte count pointer did not advance");
endmodule

// File: rtl/pit_core.sv
module pit_core
  import pit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  mode_e            mode,
  input  logic             bcd,
  input  logic             cw_wr,
  input  mode_e            cw_mode,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             cnt_en,
  input  logic             gate,
  output logic [CNT_W-1:0] cnt,
  output logic             out_q
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] reload, thr, nxt;
  logic run, armed, gate_q;
  logic gate_rise, gated_mode, m23, m45, trig_mode, step;

  assign gate_rise  = gate && !gate_q;
  assign m23        = (mode == MD_RATE) || (mode == MD_SQUARE);
  assign m45        = (mode == MD_SW_STROBE) || (mode == MD_HW_STROBE);
  assign trig_mode  = (mode == MD_ONESHOT) || (mode == MD_HW_STROBE);
  assign gated_mode = !trig_mode;
  assign step       = cnt_en && run && (!gated_mode || gate);
  assign nxt        = count_dec(cnt, bcd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      reload <= '0;
      thr    <= ONE;
      run    <= 1'b0;
      armed  <= 1'b0;
      out_q  <= 1'b1;
      gate_q <= 1'b0;
    end else begin
      gate_q <= gate;
      if (cw_wr) begin
        run   <= 1'b0;
        armed <= 1'b0;
        out_q <= (cw_mode != MD_TC_IRQ);
      end else if (load) begin
        reload <= load_val;
        thr    <= (mode == MD_SQUARE) ? count_half(load_val, bcd) : ONE;
        case (mode)
          MD_TC_IRQ: begin
            cnt <= load_val; run <= 1'b1; out_q <= 1'b0;
          end
          MD_ONESHOT, MD_HW_STROBE: armed <= 1'b1;
          default: begin
            cnt <= load_val; run <= 1'b1; out_q <= 1'b1;
          end
        endcase
      end else if (gate_rise && armed && trig_mode) begin
        cnt <= reload;
        run <= 1'b1;
        if (mode == MD_ONESHOT) out_q <= 1'b0;
      end else if (m23 && !gate) begin
        out_q <= 1'b1;
      end else if (cnt_en) begin
        if (step) begin
          case (mode)
            MD_TC_IRQ: begin
              cnt <= nxt;
              if (cnt == ONE) out_q <= 1'b1;
            end
            MD_ONESHOT: begin
              cnt <= nxt;
              if (cnt == ONE) begin out_q <= 1'b1; run <= 1'b0; end
            end
            MD_RATE, MD_SQUARE: begin
              if (cnt == ONE) begin
                cnt <= reload; out_q <= 1'b1;
              end else begin
                cnt <= nxt;
                if (nxt == thr) out_q <= 1'b0;
              end
            end
            default: begin
              cnt   <= nxt;
              out_q <= (cnt != ONE);
              if (cnt == ONE) run <= 1'b0;
            end
          endcase
        end else if (m45) begin
          out_q <= 1'b1;
        end
      end
    end
  end

  // R5: once high in mode 0 the output holds until a write
  assert_mode0_holds_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_TC_IRQ && out_q && !load && !cw_wr) |=> out_q)
    else $error("mode 0 output dropped without a write");

  // R9, R10: a strobe lasts a single tick
  assert_strobe_one_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (m45 && !out_q && cnt_en && !load && !cw_wr && !gate_rise) |=> out_q)
    else $error("strobe longer than one tick");

  // R12: gate low forces the output high in modes 2 and 3
  assert_gate_low_forces_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (m23 && !gate && !cw_wr) |=> out_q)
    else $error("output not forced high with gate low");

  // R12: gate low freezes the count in gated modes
  assert_gate_low_freezes_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (gated_mode && !gate && !load && !cw_wr) |=> $stable(cnt))
    else $error("count moved with gate low");

  // R6: an armed one-shot drops its output on a gate edge
  assert_oneshot_trigger_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_ONESHOT && armed && gate_rise && !load && !cw_wr) |=> !out_q)
    else $error("one-shot did not start on gate edge");
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int CHAN_ID = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [1:0] addr,
  input  logic [7:0] din,
  output logic [7:0] dout,
  input  logic       cnt_en,
  input  logic       gate,
  output logic       wave_out
);
  cfg_t             cfg;
  logic             cw_wr, load;
  mode_e            cw_mode;
  logic [CNT_W-1:0] load_val, cnt;

  pit_bus #(.CHAN_ID(CHAN_ID)) u_bus (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .cnt(cnt), .cfg(cfg), .cw_wr(cw_wr),
    .cw_mode(cw_mode), .load(load), .load_val(load_val), .dout(dout)
  );

  pit_core u_core (
    .clk(clk), .rst_n(rst_n), .mode(cfg.mode), .bcd(cfg.bcd),
    .cw_wr(cw_wr), .cw_mode(cw_mode), .load(load), .load_val(load_val),
    .cnt_en(cnt_en), .gate(gate), .cnt(cnt), .out_q(wave_out)
  );
endmodule

// File: tb/test_pit_channel.sv
module test_pit_channel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'b00;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic       cnt_en = 1'b0;
  logic       gate = 1'b1;
  logic       wave_out;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pit_channel #(.CHAN_ID(0)) i_pit_channel (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .dout(dout), .cnt_en(cnt_en), .gate(gate),
    .wave_out(wave_out)
  );

  // control byte, count byte (format 01), expected high run, expected low run
  localparam int NV = 8;
  localparam logic [31:0] VEC [NV] = '{
    {8'h14, 8'd4,  8'd3,  8'd1},   // R7 mode 2, N=4
    {8'h14, 8'd5,  8'd4,  8'd1},   // R7 mode 2, N=5
    {8'h16, 8'd6,  8'd3,  8'd3},   // R8 mode 3 even
    {8'h16, 8'd5,  8'd3,  8'd2},   // R8 mode 3 odd
    {8'h1E, 8'd7,  8'd4,  8'd3},   // R8 mode code 7 aliases 3
    {8'h17, 8'h10, 8'd5,  8'd5},   // R8 R11 BCD 10
    {8'h17, 8'h11, 8'd6,  8'd5},   // R8 R11 BCD 11
    {8'h1D, 8'h12, 8'd11, 8'd1}    // R7 R11 code 6, BCD 12
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    cs_n = 1'b0; wr_n = 1'b0; addr = a; din = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic bus_rd(output logic [7:0] d);
    cs_n = 1'b0; rd_n = 1'b0; addr = 2'b00;
    #1 d = dout;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic tick_n(input int n);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic set_gate(input logic v);
    gate = v;
    @(negedge clk);
  endtask

  initial begin
    #(1900000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rb;
    int h, l, h2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 reset state
    chk("R4 out after reset", wave_out, 1);
    bus_rd(rb);
    chk("R4 read after reset", rb, 8'h00);
    bus_wr(2'b00, 8'h02);
    chk("R4 R2 first byte of default format", wave_out, 1);
    bus_wr(2'b00, 8'h00);
    chk("R4 default mode 0 drives low", wave_out, 0);
    tick_n(2);
    chk("R4 default count of 2 ends", wave_out, 1);

    // R7 R8 R11 periodic modes from the table
    for (int v = 0; v < NV; v++) begin
      bus_wr(2'b11, VEC[v][31:24]);
      bus_wr(2'b00, VEC[v][23:16]);
      chk("R13 out high after count in periodic mode", wave_out, 1);
      h = 1;
      for (int k = 0; k < 400; k++) begin tick_n(1); if (wave_out) h++; else break; end
      l = 1;
      for (int k = 0; k < 400; k++) begin tick_n(1); if (!wave_out) l++; else break; end
      h2 = 1;
      for (int k = 0; k < 400; k++) begin tick_n(1); if (wave_out) h2++; else break; end
      chk((VEC[v][3] == 1'b0) ? "R8 high run" : "R7 high run", h, VEC[v][15:8]);
      chk((VEC[v][3] == 1'b0) ? "R8 low run" : "R7 low run", l, VEC[v][7:0]);
      chk("R7 R8 R11 second high run", h2, VEC[v][15:8]);
    end

    // R5 R13 mode 0
    bus_wr(2'b11, 8'h10);
    chk("R13 mode 0 control drives low", wave_out, 0);
    bus_wr(2'b00, 8'd3);
    tick_n(2);
    chk("R5 low before terminal", wave_out, 0);
    tick_n(1);
    chk("R5 high at terminal", wave_out, 1);
    tick_n(4);
    chk("R5 stays high", wave_out, 1);
    bus_wr(2'b00, 8'd2);
    chk("R5 new count drives low", wave_out, 0);
    set_gate(1'b0);
    tick_n(5);
    chk("R12 mode 0 suspended output", wave_out, 0);
    bus_rd(rb);
    chk("R12 R3 count frozen", rb, 8'd2);
    set_gate(1'b1);
    tick_n(2);
    chk("R12 resumes after gate", wave_out, 1);

    // R2 R3 two-byte format
    bus_wr(2'b11, 8'h30);
    bus_wr(2'b00, 8'h02);
    tick_n(5);
    chk("R2 low byte alone has no effect", wave_out, 0);
    bus_wr(2'b00, 8'h03);
    tick_n(2);
    bus_rd(rb);
    chk("R3 first read low byte", rb, 8'h00);
    bus_rd(rb);
    chk("R3 second read high byte", rb, 8'h03);
    tick_n(767);
    chk("R2 count 0x0302 not done", wave_out, 0);
    tick_n(1);
    chk("R2 count 0x0302 done", wave_out, 1);

    // R2 high-byte-only format
    bus_wr(2'b11, 8'h20);
    bus_wr(2'b00, 8'h01);
    tick_n(255);
    chk("R2 high-only 256 not done", wave_out, 0);
    tick_n(1);
    chk("R2 high-only 256 done", wave_out, 1);

    // R11 binary zero
    bus_wr(2'b11, 8'h30);
    bus_wr(2'b00, 8'h00);
    bus_wr(2'b00, 8'h00);
    tick_n(65535);
    chk("R11 binary zero not done", wave_out, 0);
    tick_n(1);
    chk("R11 binary zero is 65536", wave_out, 1);

    // R11 BCD zero and digit borrow
    bus_wr(2'b11, 8'h11);
    bus_wr(2'b00, 8'h00);
    tick_n(1);
    bus_rd(rb);
    chk("R11 BCD 0000 wraps to 9999", rb, 8'h99);
    tick_n(9998);
    chk("R11 BCD zero not done", wave_out, 0);
    tick_n(1);
    chk("R11 BCD zero is 10000", wave_out, 1);
    bus_wr(2'b11, 8'h31);
    bus_wr(2'b00, 8'h00);
    bus_wr(2'b00, 8'h01);
    tick_n(1);
    bus_rd(rb);
    chk("R11 BCD 0100 to 0099 low", rb, 8'h99);
    bus_rd(rb);
    chk("R11 BCD 0100 to 0099 high", rb, 8'h00);

    // R9 R13 mode 4
    bus_wr(2'b11, 8'h18);
    chk("R13 mode 4 control drives high", wave_out, 1);
    bus_wr(2'b00, 8'd3);
    tick_n(2);
    chk("R9 high before terminal", wave_out, 1);
    tick_n(1);
    chk("R9 strobe low", wave_out, 0);
    tick_n(1);
    chk("R9 strobe back high", wave_out, 1);
    tick_n(6);
    chk("R9 single strobe", wave_out, 1);
    bus_wr(2'b00, 8'd3);
    set_gate(1'b0);
    tick_n(5);
    chk("R12 mode 4 suspended", wave_out, 1);
    set_gate(1'b1);
    tick_n(2);
    chk("R12 mode 4 resumed no strobe yet", wave_out, 1);
    tick_n(1);
    chk("R12 mode 4 strobe after resume", wave_out, 0);
    tick_n(1);

    // R1 ignored writes
    bus_wr(2'b11, 8'h50);
    chk("R1 foreign select ignored", wave_out, 1);
    bus_wr(2'b11, 8'h00);
    chk("R1 format 00 ignored", wave_out, 1);
    cs_n = 1'b1; wr_n = 1'b0; addr = 2'b11; din = 8'h10;
    @(negedge clk);
    wr_n = 1'b1;
    chk("R1 write without chip select ignored", wave_out, 1);

    // R10 mode 5
    set_gate(1'b0);
    bus_wr(2'b11, 8'h1A);
    bus_wr(2'b00, 8'd2);
    tick_n(5);
    chk("R10 no count without trigger", wave_out, 1);
    set_gate(1'b1);
    tick_n(1);
    chk("R10 high before terminal", wave_out, 1);
    tick_n(1);
    chk("R10 strobe low", wave_out, 0);
    tick_n(1);
    chk("R10 strobe back high", wave_out, 1);

    // R6 mode 1
    set_gate(1'b0);
    bus_wr(2'b11, 8'h12);
    chk("R13 mode 1 control drives high", wave_out, 1);
    bus_wr(2'b00, 8'd3);
    tick_n(2);
    chk("R6 no pulse without trigger", wave_out, 1);
    set_gate(1'b1);
    chk("R6 trigger drives low", wave_out, 0);
    tick_n(2);
    chk("R6 still low", wave_out, 0);
    set_gate(1'b0);
    set_gate(1'b1);
    tick_n(2);
    chk("R6 retrigger extends pulse", wave_out, 0);
    tick_n(1);
    chk("R6 pulse ends", wave_out, 1);
    tick_n(3);
    chk("R6 stays high", wave_out, 1);

    // R12 mode 2 gate forcing
    bus_wr(2'b11, 8'h14);
    bus_wr(2'b00, 8'd4);
    tick_n(3);
    chk("R7 low phase", wave_out, 0);
    set_gate(1'b0);
    chk("R12 gate low forces high", wave_out, 1);
    tick_n(5);
    chk("R12 stays high with gate low", wave_out, 1);
    set_gate(1'b1);
    tick_n(3);
    chk("R12 high after resume", wave_out, 1);
    tick_n(1);
    chk("R12 low after full period", wave_out, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule